// File: doc/BRIEF.md
# GHASH Key Power Table Generator

This unit prepares the multiplier constants that an aggregated GHASH datapath needs before it can fold several 128-bit blocks per reduction. A single start pulse delivers the 128-bit hash key and a requested table depth. The unit first derives the doubled key H' by multiplying H by x in the bit-reflected field representation. It then runs a bit-serial reflected field multiplier to build successive powers of H', writing each result into a small internal table that the hashing engine reads combinationally.

A run writes as many entries as the effective count asks for. Entries above that count keep what they held before. A done flag rises when the final entry is in place and stays high until the next accepted start. A start that arrives while a run is in progress is discarded.

Top module: `ghk_pow_gen`

## Requirements
- R1: Entry 0 holds H' = {H[126:0],1'b0} XOR (H[127] ? 128'hC2000000000000000000000000000001 : 0). The shift moves bit 63 into bit 64, and bit k stands for the coefficient of x^k.
- R2: For 1 <= i < n, entry i equals H' (x) entry i-1. Here a (x) b = a*b*x^-127 mod P, with P = x^128+x^127+x^126+x^121+1.
- R3: The effective count n equals count_i, except that 0 gives 1 and any value above 8 gives 8. Only entries 0..n-1 are written, and entries n..7 keep their previous contents.
- R4: done_o reads 1 exactly 130*(n-1) rising edges after the edge that accepts start. With n = 1, done_o is already high right after the accepting edge and no multiply is started.
- R5: done_o is cleared by an accepted start that leads to n > 1. It rises when the last entry is written and then holds until the next accepted start.
- R6: While a run is in progress, start_i, key_i and count_i are ignored. The run's table contents and its timing do not change.
- R7: After reset, done_o is 0 and all eight entries read zero.
- R8: rd_data_o shows the entry addressed by rd_idx_i in the same cycle, with no register in the read path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only when no run is in progress |
| key_i | input | 128 | Hash key H, sampled on the accepting edge |
| count_i | input | 4 | Requested number of table entries |
| done_o | output | 1 | High once the table run has completed |
| rd_idx_i | input | 3 | Table read index |
| rd_data_o | output | 128 | Table entry at rd_idx_i |

## Verification
The assertions assume that the reset is released synchronously and that start_i is a plain level sampled on clock edges. They do not require count_i to be in range, because the clamp is part of the behaviour being checked. The stimulus drives every input on the falling edge and pulses start only for one cycle. It deliberately raises start during a run, with a different key and count, so that the discard path is exercised. Out-of-range counts of 0 and 12 are applied, so the assertion on the index bound sees clamped values.

// File: rtl/ghk_pkg.sv
package ghk_pkg;
    localparam int unsigned BLK_W = 128;
    // Low 128 bits of the reflected reduction polynomial (x^127+x^126+x^121+1)
    localparam logic [BLK_W-1:0] RED_LOW = 128'hC200_0000_0000_0000_0000_0000_0000_0001;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DONE   = 2'd3
    } gen_state_e;
endpackage

// File: rtl/ghk_key_shift.sv
module ghk_key_shift
    import ghk_pkg::*;
(
    input  logic [BLK_W-1:0] key_i,
    output logic [BLK_W-1:0] hp_o
);
    logic [63:0] lane_lo, lane_hi;

    always_comb begin
        lane_lo = {key_i[62:0], 1'b0};
        lane_hi = {key_i[126:64], key_i[63]};
        hp_o    = {lane_hi, lane_lo} ^ (key_i[BLK_W-1] ? RED_LOW : '0);
    end

    // R1
    always_comb begin
        keybit_carry_chk: assert (hp_o[0] == key_i[BLK_W-1]);
    end
endmodule

// File: rtl/ghk_rmul.sv
module ghk_rmul
    import ghk_pkg::*;
#(
    parameter int unsigned W = BLK_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         vld_o,
    output logic [W-1:0] res_o
);
    localparam int unsigned BIT_W = $clog2(W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

    typedef struct packed {
        logic             busy;
        logic             vld;
        logic [BIT_W-1:0] bit_idx;
        logic [W-1:0]     acc;
        logic [W-1:0]     a;
        logic [W-1:0]     b;
    } mul_reg_t;

    mul_reg_t r_d, r_q;
    logic [W-1:0] sum;

    // multiply by x^-1 modulo the reflected polynomial
    function automatic logic [W-1:0] div_x(input logic [W-1:0] v);
        logic [W-1:0] t;
        if (v[0]) begin
            t = (v ^ RED_LOW) >> 1;
            t[W-1] = 1'b1;
        end else begin
            t = v >> 1;
        end
        return t;
    endfunction

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        sum     = r_q.acc ^ (r_q.b[r_q.bit_idx] ? r_q.a : '0);
        if (!r_q.busy && start_i) begin
            r_d.busy    = 1'b1;
            r_d.bit_idx = '0;
            r_d.acc     = '0;
            r_d.a       = a_i;
            r_d.b       = b_i;
        end else if (r_q.busy) begin
            if (r_q.bit_idx == LAST_BIT) begin
                r_d.acc  = sum;
                r_d.busy = 1'b0;
                r_d.vld  = 1'b1;
            end else begin
                r_d.acc     = div_x(sum);
                r_d.bit_idx = r_q.bit_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign vld_o = r_q.vld;
    assign res_o = r_q.acc;

    // R2
    mul_finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.busy && r_q.bit_idx == LAST_BIT) |=> (vld_o && !r_q.busy));
    // R4
    vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |=> !vld_o);
endmodule

// File: rtl/ghk_pow_table.sv
module ghk_pow_table #(
    parameter int unsigned W     = 128,
    parameter int unsigned DEPTH = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [W-1:0]             wdata_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [W-1:0]             rdata_o
);
    logic [W-1:0] tab_d [DEPTH];
    logic [W-1:0] tab_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) tab_d[i] = tab_q[i];
        if (we_i) tab_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) tab_q[i] <= tab_d[i];
        end
    end

    assign rdata_o = tab_q[raddr_i];
endmodule

// File: rtl/ghk_pow_gen.sv
module ghk_pow_gen
    import ghk_pkg::*;
#(
    parameter int unsigned MAX_POW = 8,
    localparam int unsigned CNT_W  = $clog2(MAX_POW + 1),
    localparam int unsigned IDX_W  = $clog2(MAX_POW)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [BLK_W-1:0]   key_i,
    input  logic [CNT_W-1:0]   count_i,
    output logic               done_o,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [BLK_W-1:0]   rd_data_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_POW);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        gen_state_e       state;
        logic             done;
        logic [BLK_W-1:0] hp;
        logic [BLK_W-1:0] prev;
        logic [CNT_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } gen_reg_t;

    gen_reg_t r_d, r_q;

    logic [BLK_W-1:0] hp_new;
    logic [CNT_W-1:0] eff_cnt;
    logic             accept;
    logic             busy;
    logic             mul_start, mul_vld;
    logic [BLK_W-1:0] mul_res;
    logic             tab_we;
    logic [IDX_W-1:0] tab_waddr;
    logic [BLK_W-1:0] tab_wdata;

    ghk_key_shift i_shift (
        .key_i (key_i),
        .hp_o  (hp_new)
    );

    ghk_rmul #(.W(BLK_W)) i_mul (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (mul_start),
        .a_i     (r_q.hp),
        .b_i     (r_q.prev),
        .vld_o   (mul_vld),
        .res_o   (mul_res)
    );

    ghk_pow_table #(.W(BLK_W), .DEPTH(MAX_POW)) i_tab (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (tab_we),
        .waddr_i (tab_waddr),
        .wdata_i (tab_wdata),
        .raddr_i (rd_idx_i),
        .rdata_o (rd_data_o)
    );

    always_comb begin
        if (count_i == '0)          eff_cnt = CNT_ONE;
        else if (count_i > CNT_MAX) eff_cnt = CNT_MAX;
        else                        eff_cnt = count_i;
        busy   = (r_q.state == ST_LAUNCH) || (r_q.state == ST_WAIT);
        accept = start_i && !busy;
    end

    always_comb begin
        r_d       = r_q;
        mul_start = 1'b0;
        tab_we    = 1'b0;
        tab_waddr = '0;
        tab_wdata = hp_new;
        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    tab_we  = 1'b1;
                    r_d.hp   = hp_new;
                    r_d.prev = hp_new;
                    r_d.cnt  = eff_cnt;
                    r_d.idx  = CNT_ONE;
                    if (eff_cnt == CNT_ONE) begin
                        r_d.state = ST_DONE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_LAUNCH;
                        r_d.done  = 1'b0;
                    end
                end
            end
            ST_LAUNCH: begin
                mul_start = 1'b1;
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mul_vld) begin
                    tab_we    = 1'b1;
                    tab_waddr = r_q.idx[IDX_W-1:0];
                    tab_wdata = mul_res;
                    r_d.prev  = mul_res;
                    if (r_q.idx == r_q.cnt - CNT_ONE) begin
                        r_d.state = ST_DONE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.idx   = r_q.idx + CNT_ONE;
                        r_d.state = ST_LAUNCH;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign done_o = r_q.done;

    // R6
    start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && start_i) |=> ($stable(r_q.hp) && $stable(r_q.cnt)));
    // R5
    done_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(done_o) |-> $past(start_i));
    // R3
    idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state != ST_IDLE) |-> (r_q.idx <= r_q.cnt && r_q.cnt >= CNT_ONE && r_q.cnt <= CNT_MAX));
    // R4
    single_nomul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && eff_cnt == CNT_ONE) |=> (done_o && r_q.state == ST_DONE));
endmodule

// File: tb/test_ghk_pow_gen.sv
module test_ghk_pow_gen;
    localparam int W = 128;
    localparam int MAXP = 8;
    localparam int CW = 4;
    localparam int IW = 3;
    localparam logic [W-1:0] RLOW = 128'hC200_0000_0000_0000_0000_0000_0000_0001;
    localparam logic [W:0]   PFULL = {1'b1, RLOW};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  key = '0;
    logic [CW-1:0] cnt = '0;
    logic          done;
    logic [IW-1:0] rd_idx = '0;
    logic [W-1:0]  rd_data;

    ghk_pow_gen i_ghk_pow_gen (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .key_i     (key),
        .count_i   (cnt),
        .done_o    (done),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    always #2 clk = ~clk;

    typedef struct {
        int           idx;
        logic [W-1:0] val;
        string        req;
    } exp_t;

    exp_t         exp_q[$];
    logic [W-1:0] model_tab[MAXP];
    bit           rd_go = 1'b0;
    int           total = 0;
    int           bad = 0;

    function automatic logic [W-1:0] tb_shift(input logic [W-1:0] k);
        logic [W-1:0] r;
        r = {k[W-2:0], 1'b0};
        if (k[W-1]) r = r ^ RLOW;
        return r;
    endfunction

    function automatic logic [W-1:0] tb_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] c;
        c = '0;
        for (int i = 0; i < W; i++)
            if (b[i]) c = c ^ ({{W{1'b0}}, a} << i);
        for (int k = 0; k < W - 1; k++) begin
            if (c[0]) c = c ^ {{(W-1){1'b0}}, PFULL};
            c = c >> 1;
        end
        if (c[W]) c = c ^ {{(W-1){1'b0}}, PFULL};
        return c[W-1:0];
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected entries and compares them with the read port (R8)
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rd_go && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                rd_idx = IW'(e.idx);
                #1;
                check($sformatf("%s entry %0d (read R8)", e.req, e.idx), rd_data, e.val);
            end
        end
    end

    task automatic drain();
        rd_go = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        @(posedge clk);
        rd_go = 1'b0;
    endtask

    task automatic run_case(input logic [W-1:0] k, input int n, input bit intrude);
        int eff;
        int cyc;
        logic [W-1:0] hp;
        exp_t e;
        eff = (n == 0) ? 1 : ((n > MAXP) ? MAXP : n);
        hp = tb_shift(k);
        model_tab[0] = hp;
        for (int i = 1; i < eff; i++) model_tab[i] = tb_mul(hp, model_tab[i-1]);
        @(negedge clk);
        start = 1'b1;
        key = k;
        cnt = CW'(n);
        @(posedge clk);
        cyc = 0;
        forever begin
            @(negedge clk);
            start = intrude && (cyc == 5);
            key = (intrude && cyc == 5) ? ~k : k;
            cnt = (intrude && cyc == 5) ? CW'(2) : CW'(n);
            if (done) break;
            if (cyc > 3000) begin
                check("R4 watchdog on done", 128'(cyc), 128'(130 * (eff - 1)));
                break;
            end
            @(posedge clk);
            cyc++;
        end
        start = 1'b0;
        // R4 latency, R6 when an ignored start was raised mid-run
        check(intrude ? "R6 latency with ignored start" : "R4 done latency",
              128'(cyc), 128'(130 * (eff - 1)));
        for (int i = 0; i < MAXP; i++) begin
            e.idx = i;
            e.val = model_tab[i];
            if (intrude)     e.req = "R6";
            else if (i == 0) e.req = "R1";
            else if (i < eff) e.req = "R2";
            else             e.req = "R3";
            exp_q.push_back(e);
        end
        drain();
        // R5 done holds until the next accepted start
        check("R5 done held", 128'(done), 128'(1));
    endtask

    initial begin
        exp_t e;
        for (int i = 0; i < MAXP; i++) model_tab[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 done after reset", 128'(done), 128'(0));
        for (int i = 0; i < MAXP; i++) begin
            e.idx = i;
            e.val = '0;
            e.req = "R7";
            exp_q.push_back(e);
        end
        drain();

        run_case(128'h80F0_1234_5678_9ABC_8000_0000_0000_0001, 8, 1'b0);
        run_case(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 3, 1'b0);
        run_case(128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, 1, 1'b0);
        run_case(128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 0, 1'b0);
        run_case(128'h8000_0000_0000_0000_0000_0000_0000_0000, 12, 1'b0);
        run_case(128'hA5A5_5A5A_0F0F_F0F0_1357_9BDF_2468_ACE0, 8, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R4 act=expired exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule